// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter with Reference Divider

This block sits between an external dual-modulus prescaler and a phase detector in a frequency synthesizer. Each prescaler output pulse arrives as a one-cycle strobe. Two programmable down-counters, a swallow count A and a main count M, track these pulses. While the swallow count is running, a modulus-control output holds the prescaler at its larger ratio P+1. Once the swallow count is used up, the output switches the prescaler to ratio P until the main count ends. Each full cycle then spans M·P + A prescaler input periods. At the end of each cycle the block emits a one-cycle terminal pulse for the phase detector.

A second counter divides a reference strobe. Every R strobes it toggles a square-wave output, so the total division is 2R. It also flags each rising edge of that output as the reference event. New A, M and R values are sampled only at a counter's own wrap point. A sync strobe reloads all three counters at once, which brings the divided signal and the reference back into step.

Top module: `pulse_swallow_ctl`

## Requirements
- R1: After reset, a reset-released block shows `div_done` = 0, `ref_out` = 0 and `ref_event` = 0. `mod_ctl` is low when `a_cfg` > 0.
- R2: Within a count cycle, `mod_ctl` is low while fewer than A `fin_pulse` strobes have been taken since the cycle began. It is high from the A-th strobe to the end of the cycle.
- R3: A count cycle consists of exactly M `fin_pulse` strobes. On the clock after the edge that takes the M-th strobe, `div_done` is high for exactly one cycle, and a new cycle starts with `mod_ctl` low again if the new A > 0.
- R4: With A = 0, `mod_ctl` stays high for the whole count cycle.
- R5: A change of `a_cfg` or `m_cfg` in mid-cycle leaves the current cycle's length and swallow point unchanged. The new values apply from the next cycle.
- R6: `ref_out` toggles on the edge that takes every R-th `ref_pulse` strobe, so one full period is 2R strobes. A change of `r_cfg` applies at the next toggle.
- R7: `ref_event` is high for one cycle, exactly when `ref_out` has just risen.
- R8: A `sync` strobe reloads A, M and R from the configuration inputs and clears `ref_out`, without producing a `div_done` pulse. Counting resumes from the start of a fresh cycle.
- R9: Outputs change only in response to a `fin_pulse`, `ref_pulse` or `sync` strobe. Configuration values are meant to lie in these ranges: A from 0 to 127 with M > A, M from 8 to 1023, and R from 3 to 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fin_pulse | input | 1 | One-cycle strobe per prescaler output pulse |
| ref_pulse | input | 1 | One-cycle strobe per reference clock period |
| sync | input | 1 | Reloads all counters at once |
| a_cfg | input | AW (7) | Swallow count A |
| m_cfg | input | MW (10) | Main count M |
| r_cfg | input | RW (11) | Reference half-period count R |
| mod_ctl | output | 1 | Prescaler modulus select (low = P+1, high = P) |
| div_done | output | 1 | One-cycle pulse at the end of each count cycle |
| ref_out | output | 1 | Divided reference square wave |
| ref_event | output | 1 | One-cycle pulse on each rising edge of `ref_out` |

## Verification
The bench builds the block with its default widths of 7, 10 and 11 bits. It programs small counts (M of 8 to 12, R of 3 and 4), so that full count cycles and several reference periods fit in a short run. With these settings, the swallow point, the wrap at M, the A = 0 case and a mid-cycle reprogramming can each be seen on both sides of a boundary. A sync strobe placed inside a partly counted cycle shows that the reload discards the partial count.

// File: rtl/pulse_swallow_ctl.sv
module pulse_swallow_ctl #(
  parameter int AW = 7,
  parameter int MW = 10,
  parameter int RW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin_pulse,
  input  logic          ref_pulse,
  input  logic          sync,
  input  logic [AW-1:0] a_cfg,
  input  logic [MW-1:0] m_cfg,
  input  logic [RW-1:0] r_cfg,
  output logic          mod_ctl,
  output logic          div_done,
  output logic          ref_out,
  output logic          ref_event
);

  logic [AW-1:0] a_cnt;
  logic [MW-1:0] m_cnt;
  logic [RW-1:0] r_cnt;

  wire a_zero = (a_cnt == '0);
  wire m_last = (m_cnt == MW'(1));
  wire r_last = (r_cnt == RW'(1));

  assign mod_ctl = a_zero;

  always_ff @(posedge clk) begin
    if (!rst_n || sync) begin
      a_cnt    <= a_cfg;
      m_cnt    <= m_cfg;
      div_done <= 1'b0;
    end else begin
      div_done <= 1'b0;
      if (fin_pulse) begin
        if (m_last) begin
          a_cnt    <= a_cfg;
          m_cnt    <= m_cfg;
          div_done <= 1'b1;
        end else begin
          m_cnt <= m_cnt - MW'(1);
          if (!a_zero) a_cnt <= a_cnt - AW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sync) begin
      r_cnt     <= r_cfg;
      ref_out   <= 1'b0;
      ref_event <= 1'b0;
    end else begin
      ref_event <= 1'b0;
      if (ref_pulse) begin
        if (r_last) begin
          r_cnt     <= r_cfg;
          ref_out   <= ~ref_out;
          ref_event <= ~ref_out;
        end else begin
          r_cnt <= r_cnt - RW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pulse_swallow_ctl_chk.sv
module pulse_swallow_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic fin_pulse,
  input logic ref_pulse,
  input logic sync,
  input logic mod_ctl,
  input logic div_done,
  input logic ref_out,
  input logic ref_event
);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> !div_done);

  // R3
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> ($past(fin_pulse) && !$past(sync)));

  // R2
  mod_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_ctl) |-> (div_done || $past(sync)));

  // R9
  mod_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_ctl) |-> ($past(fin_pulse) || $past(sync)));

  // R7
  event_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_out) |-> ref_event);

  // R7
  event_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_event |-> $rose(ref_out));

  // R6
  ref_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_out) |-> ($past(ref_pulse) || $past(sync)));

  // R8
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync) |-> (!ref_out && !div_done));

endmodule

bind pulse_swallow_ctl pulse_swallow_ctl_chk u_chk (.*);

// File: tb/pulse_swallow_ctl_bench.sv
module pulse_swallow_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fin_pulse = 1'b0, ref_pulse = 1'b0, sync = 1'b0;
  logic [6:0]  a_cfg = 7'd3;
  logic [9:0]  m_cfg = 10'd10;
  logic [10:0] r_cfg = 11'd3;
  logic mod_ctl, div_done, ref_out, ref_event;

  int checks = 0, fails = 0;
  int k = 0, cur_a = 3, cur_m = 10;
  int rc = 0, cur_r = 3;
  bit rout = 1'b0;

  always #2.5 clk = ~clk;

  pulse_swallow_ctl u_pulse_swallow_ctl (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fin(input string req);
    bit exp_done;
    @(negedge clk) fin_pulse = 1'b1;
    @(negedge clk) fin_pulse = 1'b0;
    k++;
    exp_done = (k == cur_m);
    if (exp_done) begin k = 0; cur_a = a_cfg; cur_m = m_cfg; end
    chk({req, " done"}, div_done, exp_done);
    chk({req, " mod"}, mod_ctl, (k >= cur_a));
    @(negedge clk);
    chk({req, " done low"}, div_done, 0);
  endtask

  task automatic refp(input string req);
    bit exp_ev;
    @(negedge clk) ref_pulse = 1'b1;
    @(negedge clk) ref_pulse = 1'b0;
    rc++;
    exp_ev = 1'b0;
    if (rc == cur_r) begin rc = 0; rout = !rout; exp_ev = rout; cur_r = r_cfg; end
    chk({req, " ref_out"}, ref_out, rout);
    chk({req, " ref_event"}, ref_event, exp_ev);
  endtask

  task automatic do_sync();
    @(negedge clk) sync = 1'b1;
    @(negedge clk) sync = 1'b0;
    k = 0; cur_a = a_cfg; cur_m = m_cfg; rc = 0; cur_r = r_cfg; rout = 1'b0;
    chk("R8 no done", div_done, 0);
    chk("R8 ref_out clear", ref_out, 0);
    chk("R8 mod restart", mod_ctl, (cur_a == 0));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mod", mod_ctl, 0);
    chk("R1 done", div_done, 0);
    chk("R1 ref_out", ref_out, 0);
    chk("R1 ref_event", ref_event, 0);
  endtask

  task automatic t_cycles();
    for (int i = 0; i < 20; i++) fin("R2 R3 A3M10");
    repeat (5) @(negedge clk);
    chk("R9 idle mod", mod_ctl, (k >= cur_a));
    chk("R9 idle done", div_done, 0);
  endtask

  task automatic t_a_zero();
    a_cfg = 7'd0; m_cfg = 10'd8;
    do_sync();
    chk("R4 start high", mod_ctl, 1);
    for (int i = 0; i < 16; i++) fin("R4 A0M8");
  endtask

  task automatic t_midchange();
    a_cfg = 7'd3; m_cfg = 10'd10;
    do_sync();
    for (int i = 0; i < 2; i++) fin("R5 before");
    a_cfg = 7'd5; m_cfg = 10'd12;
    for (int i = 0; i < 8; i++) fin("R5 old cycle");
    for (int i = 0; i < 12; i++) fin("R5 new cycle");
  endtask

  task automatic t_sync_mid();
    for (int i = 0; i < 7; i++) fin("R8 partial");
    do_sync();
    for (int i = 0; i < 12; i++) fin("R8 after sync");
  endtask

  task automatic t_ref();
    r_cfg = 11'd3;
    do_sync();
    for (int i = 0; i < 12; i++) refp("R6 R7 R3ref");
    r_cfg = 11'd4;
    for (int i = 0; i < 16; i++) refp("R6 R7 R4ref");
    for (int i = 0; i < 2; i++) refp("R8 pre");
    do_sync();
    for (int i = 0; i < 8; i++) refp("R8 ref restart");
  endtask

  initial begin
    t_reset();
    t_cycles();
    t_a_zero();
    t_midchange();
    t_sync_mid();
    t_ref();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule